// File: doc/BRIEF.md
# Pre-Increment Stack Pointer Unit

This block keeps the pointer of a last-in first-out stack held in a byte memory. The pointer always names the slot that holds the current top item. A push first advances the pointer and then stores the byte at the new address. A pop first reads the byte at the current address, hands it out with a one-cycle valid pulse, and then steps the pointer back. Software can also load the pointer directly and read it at any time. A common use is to move the stack above a reserved region: load the address just below the free area, and the first push lands at the first free byte.

Each stack operation takes two clocks. The first is the address and update phase. The second is the memory access phase. While an operation is in flight, the unit raises `busy` and ignores every new command. Pointer arithmetic wraps modulo the pointer range and sets no flag. The byte memory sits outside the unit. It is reached through a plain address, write-strobe and read-strobe port, and read data is expected in the same cycle as the read strobe.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset, `sp_val` is 07H, and `busy`, `pop_valid`, `mem_we` and `mem_re` are all 0.
- R2: A push accepted on an idle clock gives the following behaviour in the next cycle: `sp_val` equals the old pointer plus one, and `busy` is 1. In the same cycle, `mem_we` is 1, with `mem_addr` equal to the new pointer and `mem_wdata` equal to the pushed byte. In the cycle after that, the unit is idle again.
- R3: A pop accepted on an idle clock gives the following behaviour in the next cycle: `mem_re` is 1, `mem_addr` equals the unchanged pointer, `busy` is 1 and `pop_valid` is 0. In the cycle after that, `pop_valid` is 1, `pop_data` holds the byte read, and `sp_val` equals the old pointer minus one.
- R4: A load accepted on an idle clock sets `sp_val` to `load_val` in the next cycle. It raises neither memory strobe and does not raise `busy`.
- R5: When a load arrives together with a push or a pop, the load is taken and the stack operation is dropped. No memory strobe follows, and no `pop_valid` pulse follows.
- R6: While `busy` is 1, push, pop and load requests have no effect on the pointer or on the memory port.
- R7: Pointer arithmetic wraps without a flag. A push from FFH writes at 00H, and a pop at 00H leaves the pointer at FFH.
- R8: With the default `POP_FIRST` of 0, a push and a pop requested together perform only the push.
- R9: After reset, the first push writes at 08H. After loading 2FH, the next push writes at 30H.
- R10: `pop_valid` is a single-cycle pulse, and it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Push request |
| push_data | input | DATA_W | Byte to push |
| pop_req | input | 1 | Pop request |
| pop_data | output | DATA_W | Byte taken by the last pop |
| pop_valid | output | 1 | One-cycle pulse marking `pop_data` as new |
| load_en | input | 1 | Direct pointer load request |
| load_val | input | PTR_W | Value to load into the pointer |
| sp_val | output | PTR_W | Current pointer value |
| busy | output | 1 | Stack operation in flight; commands are ignored |
| mem_addr | output | PTR_W | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | DATA_W | Memory read data, valid in the cycle of `mem_re` |

## Verification
The main push and pop behaviour is run as one sequence that pairs pushes with pops. A mismatch between the written address and the popped address therefore shows up as wrong returned data, not just as a wrong pointer. The sequence starts from the reset value, so the first slot is 08H. It then relocates the stack with a load of 2FH. Finally it runs from FEH across the FFH-to-00H boundary and back. Together these separate pre-increment from post-increment, show that the load is honoured, and show that the arithmetic wraps. Directed cases then combine requests: a load with a push, a load with a pop, a push with a pop, and requests issued while busy. Each combination shows which command wins, or that an ignored request left the pointer and the memory strobes alone.

// File: rtl/sp_pkg.sv
package sp_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_PUSH_WR = 2'd1,
      ST_POP_RD  = 2'd2
   } sp_state_e;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_LOAD = 2'd1,
      CMD_PUSH = 2'd2,
      CMD_POP  = 2'd3
   } sp_cmd_e;

endpackage

// File: rtl/sp_cmd_arb.sv
module sp_cmd_arb
   import sp_pkg::*;
#(
   parameter bit POP_FIRST = 1'b0
)(
   input  logic    push_req,
   input  logic    pop_req,
   input  logic    load_en,
   input  logic    busy,
   output sp_cmd_e cmd
);

   sp_cmd_e stack_cmd;

   generate
      if (POP_FIRST) begin : g_pop_wins
         always_comb begin
            if (pop_req)       stack_cmd = CMD_POP;
            else if (push_req) stack_cmd = CMD_PUSH;
            else               stack_cmd = CMD_NONE;
         end
      end else begin : g_push_wins
         always_comb begin
            if (push_req)      stack_cmd = CMD_PUSH;
            else if (pop_req)  stack_cmd = CMD_POP;
            else               stack_cmd = CMD_NONE;
         end
      end
   endgenerate

   always_comb begin
      if (busy)         cmd = CMD_NONE;
      else if (load_en) cmd = CMD_LOAD;
      else              cmd = stack_cmd;
   end

endmodule

// File: rtl/sp_seq.sv
module sp_seq
   import sp_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  sp_cmd_e cmd,
   output logic    busy,
   output logic    ptr_inc,
   output logic    ptr_dec,
   output logic    ptr_load,
   output logic    wdata_hold,
   output logic    wr_phase,
   output logic    rd_phase
);

   sp_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (cmd == CMD_PUSH)     state_d = ST_PUSH_WR;
            else if (cmd == CMD_POP) state_d = ST_POP_RD;
         end
         ST_PUSH_WR: state_d = ST_IDLE;
         ST_POP_RD:  state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign busy       = (state_q != ST_IDLE);
   assign ptr_inc    = (cmd == CMD_PUSH);
   assign ptr_load   = (cmd == CMD_LOAD);
   assign wdata_hold = (cmd == CMD_PUSH);
   assign wr_phase   = (state_q == ST_PUSH_WR);
   assign rd_phase   = (state_q == ST_POP_RD);
   assign ptr_dec    = rd_phase;

endmodule

// File: rtl/sp_ptr_reg.sv
module sp_ptr_reg #(
   parameter int unsigned      PTR_W     = 8,
   parameter logic [PTR_W-1:0] RESET_PTR = 8'h07
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ptr_load,
   input  logic             ptr_inc,
   input  logic             ptr_dec,
   input  logic [PTR_W-1:0] load_val,
   output logic [PTR_W-1:0] ptr
);

   localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

   logic [PTR_W-1:0] ptr_d;

   always_comb begin
      ptr_d = ptr;
      if (ptr_load)     ptr_d = load_val;
      else if (ptr_inc) ptr_d = ptr + ONE;
      else if (ptr_dec) ptr_d = ptr - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= RESET_PTR;
      else        ptr <= ptr_d;
   end

endmodule

// File: rtl/sp_pop_out.sv
module sp_pop_out #(
   parameter int unsigned DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] pop_data,
   output logic              pop_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_data  <= '0;
         pop_valid <= 1'b0;
      end else begin
         pop_valid <= capture;
         if (capture) pop_data <= rdata;
      end
   end

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
   import sp_pkg::*;
#(
   parameter int unsigned      PTR_W     = 8,
   parameter int unsigned      DATA_W    = 8,
   parameter logic [PTR_W-1:0] RESET_PTR = 8'h07,
   parameter bit               POP_FIRST = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop_req,
   output logic [DATA_W-1:0] pop_data,
   output logic              pop_valid,
   input  logic              load_en,
   input  logic [PTR_W-1:0]  load_val,
   output logic [PTR_W-1:0]  sp_val,
   output logic              busy,
   output logic [PTR_W-1:0]  mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_re,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int unsigned STACK_SLOTS = 1 << PTR_W;

   generate
      if (PTR_W < 2 || PTR_W > 16) begin : g_bad_ptr_w
         $error("stack_ptr_unit: PTR_W must lie in 2..16");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("stack_ptr_unit: DATA_W must be at least 1");
      end
      if (STACK_SLOTS < 4) begin : g_bad_slots
         $error("stack_ptr_unit: stack space too small");
      end
   endgenerate

   sp_cmd_e cmd;
   logic    ptr_inc, ptr_dec, ptr_load, wdata_hold, wr_phase, rd_phase;
   logic [DATA_W-1:0] wdata_q;

   sp_cmd_arb #(.POP_FIRST(POP_FIRST)) u_arb (
      .push_req (push_req),
      .pop_req  (pop_req),
      .load_en  (load_en),
      .busy     (busy),
      .cmd      (cmd)
   );

   sp_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .busy       (busy),
      .ptr_inc    (ptr_inc),
      .ptr_dec    (ptr_dec),
      .ptr_load   (ptr_load),
      .wdata_hold (wdata_hold),
      .wr_phase   (wr_phase),
      .rd_phase   (rd_phase)
   );

   sp_ptr_reg #(.PTR_W(PTR_W), .RESET_PTR(RESET_PTR)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ptr_load (ptr_load),
      .ptr_inc  (ptr_inc),
      .ptr_dec  (ptr_dec),
      .load_val (load_val),
      .ptr      (sp_val)
   );

   sp_pop_out #(.DATA_W(DATA_W)) u_pop (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (rd_phase),
      .rdata     (mem_rdata),
      .pop_data  (pop_data),
      .pop_valid (pop_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wdata_q <= '0;
      else if (wdata_hold) wdata_q <= push_data;
   end

   assign mem_addr  = sp_val;
   assign mem_we    = wr_phase;
   assign mem_re    = rd_phase;
   assign mem_wdata = wdata_q;

endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk #(
   parameter int unsigned PTR_W  = 8,
   parameter int unsigned DATA_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              push_req,
   input logic [DATA_W-1:0] push_data,
   input logic              pop_req,
   input logic [DATA_W-1:0] pop_data,
   input logic              pop_valid,
   input logic              load_en,
   input logic [PTR_W-1:0]  load_val,
   input logic [PTR_W-1:0]  sp_val,
   input logic              busy,
   input logic [PTR_W-1:0]  mem_addr,
   input logic              mem_we,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_re,
   input logic [DATA_W-1:0] mem_rdata
);

   assert_push_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && !pop_req && !load_en && !busy) |=>
         (mem_we && sp_val == PTR_W'($past(sp_val) + 1'b1) && mem_wdata == $past(push_data)));

   assert_push_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !busy);

   assert_pop_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !push_req && !load_en && !busy) |=>
         (mem_re && mem_addr == $past(sp_val)) ##1 (pop_valid && pop_data == $past(mem_rdata)));

   assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> (sp_val == PTR_W'($past(sp_val) - 1'b1)));

   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && !busy) |=> (sp_val == $past(load_val) && !busy && !mem_we && !mem_re));

   assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && load_en && !mem_re) |=> (sp_val == $past(sp_val) && !busy));

   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |=> !pop_valid);

endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/stack_ptr_unit_test.sv
module stack_ptr_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push_req = 1'b0;
   logic [7:0] push_data = '0;
   logic       pop_req = 1'b0;
   logic [7:0] pop_data;
   logic       pop_valid;
   logic       load_en = 1'b0;
   logic [7:0] load_val = '0;
   logic [7:0] sp_val;
   logic       busy;
   logic [7:0] mem_addr;
   logic       mem_we;
   logic [7:0] mem_wdata;
   logic       mem_re;
   logic [7:0] mem_rdata;

   logic [7:0] mem [256];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   stack_ptr_unit uut (
      .clk(clk), .rst_n(rst_n),
      .push_req(push_req), .push_data(push_data),
      .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid),
      .load_en(load_en), .load_val(load_val),
      .sp_val(sp_val), .busy(busy),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_re(mem_re), .mem_rdata(mem_rdata)
   );

   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // op codes: 0 push, 1 pop, 2 load. Fields {op, data, addr, sp_after}
   localparam logic [31:0] VEC [13] = '{
      {8'd0, 8'hA1, 8'h08, 8'h08},
      {8'd0, 8'hB2, 8'h09, 8'h09},
      {8'd1, 8'hB2, 8'h09, 8'h08},
      {8'd2, 8'h2F, 8'h00, 8'h2F},
      {8'd0, 8'hC3, 8'h30, 8'h30},
      {8'd0, 8'hD4, 8'h31, 8'h31},
      {8'd1, 8'hD4, 8'h31, 8'h30},
      {8'd1, 8'hC3, 8'h30, 8'h2F},
      {8'd2, 8'hFE, 8'h00, 8'hFE},
      {8'd0, 8'h11, 8'hFF, 8'hFF},
      {8'd0, 8'h22, 8'h00, 8'h00},
      {8'd1, 8'h22, 8'h00, 8'hFF},
      {8'd1, 8'h11, 8'hFF, 8'hFE}
   };

   task automatic do_push(input logic [7:0] d, input logic [7:0] a, input string tag);
      @(negedge clk); push_req = 1; push_data = d;
      @(negedge clk); push_req = 0;
      chk(mem_we && busy, {tag, " R2 write strobe"}, {busy, mem_we}, 3);
      chk(mem_addr == a && sp_val == a, {tag, " R2 address"}, mem_addr, a);
      chk(mem_wdata == d, {tag, " R2 data"}, mem_wdata, d);
      @(negedge clk);
      chk(!busy && !mem_we, {tag, " R2 idle"}, {busy, mem_we}, 0);
   endtask

   task automatic do_pop(input logic [7:0] d, input logic [7:0] a, input logic [7:0] s, input string tag);
      @(negedge clk); pop_req = 1;
      @(negedge clk); pop_req = 0;
      chk(mem_re && busy && !pop_valid, {tag, " R3 read phase"}, {mem_re, busy, pop_valid}, 6);
      chk(mem_addr == a, {tag, " R3 address"}, mem_addr, a);
      @(negedge clk);
      chk(pop_valid && pop_data == d, {tag, " R3 data"}, pop_data, d);
      chk(sp_val == s, {tag, " R3 pointer"}, sp_val, s);
      @(negedge clk);
      chk(!pop_valid, {tag, " R10 pulse"}, pop_valid, 0);
   endtask

   task automatic do_load(input logic [7:0] v, input string tag);
      @(negedge clk); load_en = 1; load_val = v;
      @(negedge clk); load_en = 0;
      chk(sp_val == v && !busy && !mem_we && !mem_re, {tag, " R4 load"}, sp_val, v);
   endtask

   initial begin
      foreach (mem[i]) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(sp_val == 8'h07 && !busy && !pop_valid && !mem_we && !mem_re, "R1 reset", sp_val, 7);

      for (int i = 0; i < 13; i++) begin
         logic [7:0] op, d, a, s;
         {op, d, a, s} = VEC[i];
         case (op)
            8'd0: do_push(d, a, $sformatf("vec%0d R9 R7", i));
            8'd1: do_pop(d, a, s, $sformatf("vec%0d R7", i));
            default: do_load(d, $sformatf("vec%0d", i));
         endcase
         chk(sp_val == s, $sformatf("vec%0d pointer", i), sp_val, s);
      end

      // R5: load together with push
      @(negedge clk); load_en = 1; load_val = 8'h40; push_req = 1; push_data = 8'h99;
      @(negedge clk); load_en = 0; push_req = 0;
      chk(sp_val == 8'h40 && !mem_we && !busy, "R5 load beats push", sp_val, 8'h40);
      @(negedge clk);
      chk(!mem_we && mem[8'h41] == 8'h00, "R5 push dropped", mem[8'h41], 0);

      // R5: load together with pop
      @(negedge clk); load_en = 1; load_val = 8'h50; pop_req = 1;
      @(negedge clk); load_en = 0; pop_req = 0;
      chk(sp_val == 8'h50 && !mem_re && !busy, "R5 load beats pop", sp_val, 8'h50);
      @(negedge clk);
      chk(!pop_valid && sp_val == 8'h50, "R5 pop dropped", {pop_valid, sp_val}, 8'h50);

      // R8: push and pop together
      @(negedge clk); push_req = 1; pop_req = 1; push_data = 8'h77;
      @(negedge clk); push_req = 0; pop_req = 0;
      chk(mem_we && !mem_re && mem_addr == 8'h51, "R8 push wins", mem_addr, 8'h51);
      @(negedge clk);
      chk(!pop_valid && sp_val == 8'h51, "R8 no pop", {pop_valid, sp_val}, 8'h51);

      // R6: requests during busy are ignored
      @(negedge clk); push_req = 1; push_data = 8'h88;
      @(negedge clk); push_req = 0; load_en = 1; load_val = 8'h10; pop_req = 1;
      chk(mem_we && mem_addr == 8'h52, "R6 push in flight", mem_addr, 8'h52);
      @(negedge clk); load_en = 0; pop_req = 0;
      chk(sp_val == 8'h52 && !busy && !mem_re, "R6 busy ignores", sp_val, 8'h52);
      @(negedge clk);
      chk(!pop_valid && !mem_re && sp_val == 8'h52, "R6 no late op", {pop_valid, sp_val}, 8'h52);

      // R7: pop at 00 wraps to FF
      do_load(8'h00, "wrap");
      do_pop(8'h22, 8'h00, 8'hFF, "R7 underflow");

      // R9 + R1: reset mid-run, then first push at 08
      @(negedge clk); rst_n = 0;
      @(negedge clk);
      chk(sp_val == 8'h07, "R1 reset again", sp_val, 7);
      rst_n = 1;
      do_push(8'h5A, 8'h08, "R9 first push");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule